// File: doc/BRIEF.md
# Neighbourhood Value Router for a Cellular Grid Node

This block sits in every node of a two-dimensional grid of cells that are wired only to their four orthogonal neighbours. Over one fixed, prescheduled exchange of ten clock steps, it delivers to the node's arithmetic datapath the output value of each of the eight cells around it. The four edge-adjacent values arrive in one hop. Each diagonal value arrives in two hops: a node that receives a neighbour's value passes it on once, at a right angle to the direction it came from.

All nodes run the same schedule in lockstep after a shared start pulse. Each packet carries the value and a relative source address. The receiver updates that address with the link it arrived on, keeps the packet in a single holding register, and presents it to the datapath for exactly one cycle, tagged with the source's compass position. The next packet then replaces it. No memory holds the whole neighbourhood. A one-cycle completion pulse marks the end of each exchange.

Top module: `nbr_router`

## Requirements
- R1: After reset, all link valid bits, `nb_valid` and `cycle_done` are 0.
- R2: A `start` pulse seen while idle begins an exchange in the next cycle (step 0) and captures `own_val` on that edge. Later changes of `own_val` do not affect the exchange. A `start` seen during an exchange is ignored.
- R3: A packet is 12 bits: bits [7:0] value, bits [9:8] source row offset, bits [11:10] source column offset. Each offset is 2-bit two's complement: 0, +1 = south/east, -1 = north/west. A packet the node sends from its own value has both offsets at 0. `lnk_o_vld` has one bit per direction (bit 0 N, 1 E, 2 S, 3 W) and at most one bit is set in any cycle. Counting the first exchange cycle as cycle 0, the link outputs are:
  - cycle 1: own value to S
  - cycle 2: own value to E
  - cycle 3: forwarded value to E
  - cycle 4: forwarded value to N
  - cycle 5: own value to N
  - cycle 6: own value to W
  - cycle 7: forwarded value to W
  - cycle 8: forwarded value to S
  - all other cycles: no link output
- R4: A received packet is forwarded unchanged once, on the perpendicular link given in R3. Its offsets are relative to the forwarding node: arrival from N adds -1 to the row offset, from S adds +1 to the row offset, from E adds +1 to the column offset, and from W adds -1 to the column offset.
- R5: With all neighbours present, `nb_valid` is 1 for exactly one cycle in each of cycles 2 to 9. `nb_val` carries the original value of the neighbour at N, W, NW, SW, S, E, SE and NE respectively in those cycles. `nb_valid` is 0 in all other cycles.
- R6: `nb_pos` gives the source position when `nb_valid` is 1, with this encoding: N=0, NE=1, E=2, SE=3, S=4, SW=5, W=6, NW=7.
- R7: If the packet a step expects is not valid on its link, that step raises no `nb_valid`, and no forward is sent for that packet.
- R8: `cycle_done` is 1 for exactly one cycle, cycle 10. The node is then idle and accepts a new `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Global exchange start pulse |
| own_val | input | VAL_W | This cell's output value |
| lnk_i_pkt | input | 4*PKT_W | Incoming packets, slot d from the neighbour in direction d (N,E,S,W) |
| lnk_i_vld | input | 4 | Incoming packet valid, per direction |
| lnk_o_pkt | output | PKT_W | Outgoing packet, shared by all four links |
| lnk_o_vld | output | 4 | Outgoing packet valid, one bit per direction |
| nb_valid | output | 1 | Neighbour value strobe toward the datapath |
| nb_val | output | VAL_W | Neighbour value |
| nb_pos | output | 3 | Neighbour position code |
| cycle_done | output | 1 | One-cycle end-of-exchange pulse |

## Verification
The bench wires nine routers into a 3x3 grid and checks every node each cycle. The centre node has a full neighbourhood. The edge and corner nodes show that a missing source gives no strobe, which tells absent packets apart from stale holding contents. Directed patterns use all-zero values, all-ones values, an alternating 0xAA/0x55 checkerboard, and a distinct value per cell; the distinct values reveal any swap between positions. Random rounds also change `own_val` after the start and pulse `start` again mid-exchange, to separate capture timing from later input activity. The centre's link outputs are compared with the expected packet, including the relabelled offsets of forwarded packets.

// File: rtl/nbr_pkg.sv
package nbr_pkg;

    localparam int NUM_DIR   = 4;
    localparam int NUM_STEPS = 10;
    localparam int STEP_W    = $clog2(NUM_STEPS);
    localparam int OFF_W     = 2;
    localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(NUM_STEPS - 1);

    typedef enum logic [1:0] {
        DIR_N = 2'd0,
        DIR_E = 2'd1,
        DIR_S = 2'd2,
        DIR_W = 2'd3
    } dir_e;

    typedef enum logic [2:0] {
        POS_N  = 3'd0,
        POS_NE = 3'd1,
        POS_E  = 3'd2,
        POS_SE = 3'd3,
        POS_S  = 3'd4,
        POS_SW = 3'd5,
        POS_W  = 3'd6,
        POS_NW = 3'd7
    } pos_e;

    typedef struct packed {
        logic tx_en;
        logic tx_fwd;
        dir_e tx_dir;
        logic rx_en;
        dir_e rx_dir;
    } step_ctl_t;

    // Fixed lockstep schedule: each received value is forwarded one step
    // later on a perpendicular link, so diagonals arrive in two hops.
    function automatic step_ctl_t step_decode(input logic [STEP_W-1:0] s);
        step_ctl_t c;
        c = '0;
        case (s)
            4'd0: begin c.tx_en = 1'b1; c.tx_dir = DIR_S; end
            4'd1: begin c.rx_en = 1'b1; c.rx_dir = DIR_N;
                        c.tx_en = 1'b1; c.tx_dir = DIR_E; end
            4'd2: begin c.rx_en = 1'b1; c.rx_dir = DIR_W;
                        c.tx_en = 1'b1; c.tx_fwd = 1'b1; c.tx_dir = DIR_E; end
            4'd3: begin c.rx_en = 1'b1; c.rx_dir = DIR_W;
                        c.tx_en = 1'b1; c.tx_fwd = 1'b1; c.tx_dir = DIR_N; end
            4'd4: begin c.rx_en = 1'b1; c.rx_dir = DIR_S;
                        c.tx_en = 1'b1; c.tx_dir = DIR_N; end
            4'd5: begin c.rx_en = 1'b1; c.rx_dir = DIR_S;
                        c.tx_en = 1'b1; c.tx_dir = DIR_W; end
            4'd6: begin c.rx_en = 1'b1; c.rx_dir = DIR_E;
                        c.tx_en = 1'b1; c.tx_fwd = 1'b1; c.tx_dir = DIR_W; end
            4'd7: begin c.rx_en = 1'b1; c.rx_dir = DIR_E;
                        c.tx_en = 1'b1; c.tx_fwd = 1'b1; c.tx_dir = DIR_S; end
            4'd8: begin c.rx_en = 1'b1; c.rx_dir = DIR_N; end
            default: c = '0;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/nbr_sequencer.sv
module nbr_sequencer
    import nbr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    output logic              run,
    output logic [STEP_W-1:0] cnt,
    output logic              capture,
    output logic              done,
    output step_ctl_t         ctl
);

    typedef struct packed {
        logic              run;
        logic [STEP_W-1:0] cnt;
        logic              done;
    } seq_st_t;

    seq_st_t s_d, s_q;

    always_comb begin
        s_d      = s_q;
        s_d.done = 1'b0;
        if (!s_q.run) begin
            if (start) begin
                s_d.run = 1'b1;
                s_d.cnt = '0;
            end
        end else if (s_q.cnt == LAST_STEP) begin
            s_d.run  = 1'b0;
            s_d.cnt  = '0;
            s_d.done = 1'b1;
        end else begin
            s_d.cnt = s_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign run     = s_q.run;
    assign cnt     = s_q.cnt;
    assign done    = s_q.done;
    assign capture = !s_q.run && start;
    assign ctl     = s_q.run ? step_decode(s_q.cnt) : '0;

endmodule

// File: rtl/nbr_rx_select.sv
module nbr_rx_select
    import nbr_pkg::*;
#(
    parameter int VAL_W = 8,
    localparam int PKT_W = VAL_W + 2 * OFF_W
) (
    input  logic [NUM_DIR*PKT_W-1:0] lnk_i_pkt,
    input  logic [NUM_DIR-1:0]       lnk_i_vld,
    input  dir_e                     rx_dir,
    output logic                     rx_vld,
    output logic [VAL_W-1:0]         rx_val,
    output logic [OFF_W-1:0]         rx_row,
    output logic [OFF_W-1:0]         rx_col
);

    logic [PKT_W-1:0] slot [NUM_DIR];

    for (genvar d = 0; d < NUM_DIR; d++) begin : g_slot
        assign slot[d] = lnk_i_pkt[d*PKT_W +: PKT_W];
    end

    logic [PKT_W-1:0] sel;
    logic [OFF_W-1:0] row_in, col_in;

    always_comb begin
        sel    = slot[rx_dir];
        rx_vld = lnk_i_vld[rx_dir];
        rx_val = sel[VAL_W-1:0];
        row_in = sel[VAL_W +: OFF_W];
        col_in = sel[VAL_W+OFF_W +: OFF_W];
        rx_row = row_in;
        rx_col = col_in;
        // offsets become relative to this node: add the sender's position
        case (rx_dir)
            DIR_N: rx_row = row_in - 1'b1;
            DIR_S: rx_row = row_in + 1'b1;
            DIR_E: rx_col = col_in + 1'b1;
            DIR_W: rx_col = col_in - 1'b1;
            default: ;
        endcase
    end

endmodule

// File: rtl/nbr_pos_code.sv
module nbr_pos_code
    import nbr_pkg::*;
(
    input  logic [OFF_W-1:0] row,
    input  logic [OFF_W-1:0] col,
    output pos_e             pos
);

    always_comb begin
        case ({row, col})
            4'b11_00: pos = POS_N;
            4'b11_01: pos = POS_NE;
            4'b00_01: pos = POS_E;
            4'b01_01: pos = POS_SE;
            4'b01_00: pos = POS_S;
            4'b01_11: pos = POS_SW;
            4'b00_11: pos = POS_W;
            4'b11_11: pos = POS_NW;
            default:  pos = POS_N;
        endcase
    end

endmodule

// File: rtl/nbr_router.sv
module nbr_router
    import nbr_pkg::*;
#(
    parameter int VAL_W = 8,
    localparam int PKT_W = VAL_W + 2 * OFF_W
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     start,
    input  logic [VAL_W-1:0]         own_val,
    input  logic [NUM_DIR*PKT_W-1:0] lnk_i_pkt,
    input  logic [NUM_DIR-1:0]       lnk_i_vld,
    output logic [PKT_W-1:0]         lnk_o_pkt,
    output logic [NUM_DIR-1:0]       lnk_o_vld,
    output logic                     nb_valid,
    output logic [VAL_W-1:0]         nb_val,
    output logic [2:0]               nb_pos,
    output logic                     cycle_done
);

    typedef struct packed {
        logic [VAL_W-1:0]   own;
        logic [VAL_W-1:0]   hval;
        logic [OFF_W-1:0]   hrow;
        logic [OFF_W-1:0]   hcol;
        logic               nbv;
        logic [NUM_DIR-1:0] txv;
        logic [PKT_W-1:0]   txp;
    } node_st_t;

    node_st_t n_d, n_q;

    logic              seq_run;
    logic [STEP_W-1:0] seq_cnt;
    logic              seq_cap;
    logic              seq_done;
    step_ctl_t         ctl;

    nbr_sequencer u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .run     (seq_run),
        .cnt     (seq_cnt),
        .capture (seq_cap),
        .done    (seq_done),
        .ctl     (ctl)
    );

    logic             rx_vld;
    logic [VAL_W-1:0] rx_val;
    logic [OFF_W-1:0] rx_row, rx_col;

    nbr_rx_select #(.VAL_W(VAL_W)) u_rx (
        .lnk_i_pkt (lnk_i_pkt),
        .lnk_i_vld (lnk_i_vld),
        .rx_dir    (ctl.rx_dir),
        .rx_vld    (rx_vld),
        .rx_val    (rx_val),
        .rx_row    (rx_row),
        .rx_col    (rx_col)
    );

    pos_e hold_pos;

    nbr_pos_code u_pos (
        .row (n_q.hrow),
        .col (n_q.hcol),
        .pos (hold_pos)
    );

    always_comb begin
        n_d     = n_q;
        n_d.nbv = 1'b0;
        n_d.txv = '0;
        n_d.txp = '0;

        if (seq_cap) n_d.own = own_val;

        // single holding register: each arrival replaces the previous one
        if (ctl.rx_en && rx_vld) begin
            n_d.nbv  = 1'b1;
            n_d.hval = rx_val;
            n_d.hrow = rx_row;
            n_d.hcol = rx_col;
        end

        if (ctl.tx_en) begin
            if (!ctl.tx_fwd) begin
                n_d.txv[ctl.tx_dir] = 1'b1;
                n_d.txp = {{OFF_W{1'b0}}, {OFF_W{1'b0}}, n_q.own};
            end else if (n_q.nbv) begin
                n_d.txv[ctl.tx_dir] = 1'b1;
                n_d.txp = {n_q.hcol, n_q.hrow, n_q.hval};
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) n_q <= '0;
        else        n_q <= n_d;
    end

    assign lnk_o_pkt  = n_q.txp;
    assign lnk_o_vld  = n_q.txv;
    assign nb_valid   = n_q.nbv;
    assign nb_val     = n_q.hval;
    assign nb_pos     = hold_pos;
    assign cycle_done = seq_done;

endmodule

// File: rtl/nbr_router_chk.sv
module nbr_router_chk
    import nbr_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic [NUM_DIR-1:0] lnk_o_vld,
    input logic              nb_valid,
    input logic [2:0]        nb_pos,
    input logic              cycle_done,
    input logic              run,
    input logic [STEP_W-1:0] cnt
);

    function automatic logic [2:0] sched_pos(input logic [STEP_W-1:0] s);
        case (s)
            4'd1:    return 3'd0;
            4'd2:    return 3'd6;
            4'd3:    return 3'd7;
            4'd4:    return 3'd5;
            4'd5:    return 3'd4;
            4'd6:    return 3'd2;
            4'd7:    return 3'd3;
            4'd8:    return 3'd1;
            default: return 3'd0;
        endcase
    endfunction

    AST_TX_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(lnk_o_vld)); // R3

    AST_TX_IN_EXCHANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (|lnk_o_vld) |-> $past(run)); // R3

    AST_NB_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        nb_valid |-> ($past(run) && $past(cnt) != '0)); // R5

    AST_POS_MATCHES_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        nb_valid |-> nb_pos == sched_pos($past(cnt))); // R6

    AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (run && cnt != LAST_STEP) |=> (run && cnt == $past(cnt) + 1'b1)); // R2

    AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        cycle_done |-> ($past(run) && $past(cnt) == LAST_STEP)); // R8

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        cycle_done |=> !cycle_done); // R8

endmodule

bind nbr_router nbr_router_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .lnk_o_vld  (lnk_o_vld),
    .nb_valid   (nb_valid),
    .nb_pos     (nb_pos),
    .cycle_done (cycle_done),
    .run        (seq_run),
    .cnt        (seq_cnt)
);

// File: tb/tb_nbr_router.sv
module tb_nbr_router;

    localparam int VW = 8;
    localparam int PW = 12;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    always #4 clk = ~clk;

    logic [VW-1:0] own_in [3][3];
    logic [VW-1:0] own_ex [3][3];
    logic [PW-1:0] po     [3][3];
    logic [3:0]    vo     [3][3];
    logic          nbvl   [3][3];
    logic [VW-1:0] nbv    [3][3];
    logic [2:0]    nbp    [3][3];
    logic          dn     [3][3];

    for (genvar r = 0; r < 3; r++) begin : g_r
        for (genvar c = 0; c < 3; c++) begin : g_c
            logic [4*PW-1:0] ip;
            logic [3:0]      iv;
            if (r > 0) begin : g_n
                assign ip[0*PW +: PW] = po[r-1][c]; assign iv[0] = vo[r-1][c][2];
            end else begin : g_nn
                assign ip[0*PW +: PW] = '0; assign iv[0] = 1'b0;
            end
            if (c < 2) begin : g_e
                assign ip[1*PW +: PW] = po[r][c+1]; assign iv[1] = vo[r][c+1][3];
            end else begin : g_ne
                assign ip[1*PW +: PW] = '0; assign iv[1] = 1'b0;
            end
            if (r < 2) begin : g_s
                assign ip[2*PW +: PW] = po[r+1][c]; assign iv[2] = vo[r+1][c][0];
            end else begin : g_ns
                assign ip[2*PW +: PW] = '0; assign iv[2] = 1'b0;
            end
            if (c > 0) begin : g_w
                assign ip[3*PW +: PW] = po[r][c-1]; assign iv[3] = vo[r][c-1][1];
            end else begin : g_nw
                assign ip[3*PW +: PW] = '0; assign iv[3] = 1'b0;
            end
            if (r == 1 && c == 1) begin : g_dut
                nbr_router dut (
                    .clk(clk), .rst_n(rst_n), .start(start), .own_val(own_in[r][c]),
                    .lnk_i_pkt(ip), .lnk_i_vld(iv), .lnk_o_pkt(po[r][c]), .lnk_o_vld(vo[r][c]),
                    .nb_valid(nbvl[r][c]), .nb_val(nbv[r][c]), .nb_pos(nbp[r][c]),
                    .cycle_done(dn[r][c]));
            end else begin : g_node
                nbr_router u_node (
                    .clk(clk), .rst_n(rst_n), .start(start), .own_val(own_in[r][c]),
                    .lnk_i_pkt(ip), .lnk_i_vld(iv), .lnk_o_pkt(po[r][c]), .lnk_o_vld(vo[r][c]),
                    .nb_valid(nbvl[r][c]), .nb_val(nbv[r][c]), .nb_pos(nbp[r][c]),
                    .cycle_done(dn[r][c]));
            end
        end
    end

    int n_vec = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // delivery plan per cycle k (2..9): source offset and position code
    function automatic void plan(input int k, output int dr, output int dc, output int pc);
        case (k)
            2: begin dr = -1; dc =  0; pc = 0; end
            3: begin dr =  0; dc = -1; pc = 6; end
            4: begin dr = -1; dc = -1; pc = 7; end
            5: begin dr =  1; dc = -1; pc = 5; end
            6: begin dr =  1; dc =  0; pc = 4; end
            7: begin dr =  0; dc =  1; pc = 2; end
            8: begin dr =  1; dc =  1; pc = 3; end
            default: begin dr = -1; dc = 1; pc = 1; end
        endcase
    endfunction

    function automatic logic [1:0] off2(input int o);
        return (o < 0) ? 2'b11 : ((o > 0) ? 2'b01 : 2'b00);
    endfunction

    // expected centre link output at cycle k
    task automatic exp_link(input int k, output logic [3:0] v, output logic [PW-1:0] p);
        v = 4'b0000; p = '0;
        case (k)
            1: begin v = 4'b0100; p = {4'b0000, own_ex[1][1]}; end
            2: begin v = 4'b0010; p = {4'b0000, own_ex[1][1]}; end
            3: begin v = 4'b0010; p = {off2(0), off2(-1), own_ex[0][1]}; end
            4: begin v = 4'b0001; p = {off2(-1), off2(0), own_ex[1][0]}; end
            5: begin v = 4'b0001; p = {4'b0000, own_ex[1][1]}; end
            6: begin v = 4'b1000; p = {4'b0000, own_ex[1][1]}; end
            7: begin v = 4'b1000; p = {off2(0), off2(1), own_ex[2][1]}; end
            8: begin v = 4'b0100; p = {off2(1), off2(0), own_ex[1][2]}; end
            default: ;
        endcase
    endtask

    task automatic check_cycle(input int k);
        int dr, dc, pc, sr, sc;
        bit ev, inside_grid;
        logic [3:0] lv;
        logic [PW-1:0] lp;
        for (int r = 0; r < 3; r++) begin
            for (int c = 0; c < 3; c++) begin
                plan(k, dr, dc, pc);
                sr = r + dr; sc = c + dc;
                inside_grid = (sr >= 0 && sr < 3 && sc >= 0 && sc < 3);
                ev = (k >= 2 && k <= 9) && inside_grid;
                chk(nbvl[r][c] == ev, (k >= 2 && k <= 9 && !inside_grid) ? "R7" : "R5",
                    $sformatf("nb_valid node%0d%0d cyc%0d", r, c, k), int'(nbvl[r][c]), int'(ev));
                if (ev && nbvl[r][c]) begin
                    chk(nbv[r][c] == own_ex[sr][sc], "R5",
                        $sformatf("nb_val node%0d%0d cyc%0d", r, c, k),
                        int'(nbv[r][c]), int'(own_ex[sr][sc]));
                    chk(nbp[r][c] == 3'(pc), "R6",
                        $sformatf("nb_pos node%0d%0d cyc%0d", r, c, k), int'(nbp[r][c]), pc);
                end
                chk(dn[r][c] == (k == 10), "R8",
                    $sformatf("cycle_done node%0d%0d cyc%0d", r, c, k), int'(dn[r][c]), int'(k == 10));
            end
        end
        exp_link(k, lv, lp);
        chk(vo[1][1] == lv, "R3", $sformatf("lnk_o_vld cyc%0d", k), int'(vo[1][1]), int'(lv));
        if (lv != 0)
            chk(po[1][1] == lp, (k == 3 || k == 4 || k == 7 || k == 8) ? "R4" : "R3",
                $sformatf("lnk_o_pkt cyc%0d", k), int'(po[1][1]), int'(lp));
    endtask

    // mode: 0 random, 1 all zero, 2 all ones, 3 distinct, 4 checkerboard
    task automatic run_round(input int mode, input bit restart_mid);
        for (int r = 0; r < 3; r++)
            for (int c = 0; c < 3; c++) begin
                case (mode)
                    1: own_ex[r][c] = 8'h00;
                    2: own_ex[r][c] = 8'hFF;
                    3: own_ex[r][c] = 8'(16 * r + c + 1);
                    4: own_ex[r][c] = ((r + c) % 2 == 0) ? 8'hAA : 8'h55;
                    default: own_ex[r][c] = 8'($urandom);
                endcase
                own_in[r][c] = own_ex[r][c];
            end
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        // R2: values seen after the start edge must not leak into the exchange
        for (int r = 0; r < 3; r++)
            for (int c = 0; c < 3; c++) own_in[r][c] = ~own_ex[r][c];
        for (int k = 0; k <= 10; k++) begin
            check_cycle(k);
            start = (restart_mid && (k == 3 || k == 6)); // R2: ignored while running
            @(negedge clk);
        end
        start = 1'b0;
        for (int r = 0; r < 3; r++)
            for (int c = 0; c < 3; c++)
                chk(nbvl[r][c] == 1'b0 && vo[r][c] == 4'b0000, "R2",
                    $sformatf("idle after exchange node%0d%0d", r, c), int'(nbvl[r][c]), 0);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        for (int r = 0; r < 3; r++)
            for (int c = 0; c < 3; c++) begin own_in[r][c] = '0; own_ex[r][c] = '0; end
        repeat (3) @(negedge clk);
        for (int r = 0; r < 3; r++)
            for (int c = 0; c < 3; c++) begin
                chk(vo[r][c] == 4'b0000, "R1", "reset lnk_o_vld", int'(vo[r][c]), 0);
                chk(nbvl[r][c] == 1'b0, "R1", "reset nb_valid", int'(nbvl[r][c]), 0);
                chk(dn[r][c] == 1'b0, "R1", "reset cycle_done", int'(dn[r][c]), 0);
            end
        rst_n = 1'b1;
        @(negedge clk);
        run_round(1, 1'b0);
        run_round(2, 1'b0);
        run_round(3, 1'b1);
        run_round(4, 1'b0);
        for (int i = 0; i < 60; i++) begin
            run_round(0, ($urandom % 3) == 0);
            repeat ($urandom % 3) @(negedge clk);
        end
        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_vec++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected done");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

endmodule